// File: doc/BRIEF.md
# Master Clock Loss Power-Save Controller

This block watches an audio master clock from a free-running reference clock. The master clock passes through a two-stage synchroniser, and every transition restarts an idle timer. If the timer reaches its programmed limit with no transition, the block enters a power-saving state. In that state it holds the DAC path powered down and keeps the digital filter in reset. The first transition after an outage brings the block back to normal operation, with no software action needed.

A small control register file stays writable and readable in every state, and its contents survive an outage. The applied volume is kept separate from the stored volume register. The applied volume takes the stored value only when the volume-update strobe is pulsed in normal operation. When the clock is lost, the applied volume is forced to the mute code. It stays muted after the clock returns, until software pulses the strobe again.

With the default 50 MHz reference clock and an idle limit of 250 cycles, loss is declared about 5 µs after the last master-clock edge. This lies inside the required 2 µs to 10 µs entry window. A master clock whose period stays under 1000 ns always produces transitions well inside the limit.

Top module: `mclk_pwrsave`

## Requirements
- R1: After reset, `dac_pd_o` and `flt_rst_o` are 0, `vol_o` equals the mute code (default 0), and every register reads back 0.
- R2: After `LOSS_CYC` consecutive reference cycles with no master-clock transition, `dac_pd_o` and `flt_rst_o` rise. With the defaults, this falls between 2 µs and 10 µs after the last transition.
- R3: While the master clock toggles with any period below 1000 ns, `dac_pd_o` stays 0.
- R4: When the master clock toggles again after an outage, `dac_pd_o` and `flt_rst_o` fall within 4 reference cycles of the first transition.
- R5: While powered down, `vol_o` equals the mute code, and pulses of `vol_upd_i` have no effect on it.
- R6: After recovery, `vol_o` stays at the mute code until `vol_upd_i` is pulsed. On the cycle after the pulse, it takes the stored volume register, which is register address 0.
- R7: Register writes (`wr_en_i`, `wr_addr_i`, `wr_data_i`) and reads (`rd_addr_i` to `rd_data_o`, combinational) work in every state. Contents written before or during an outage are kept through it.
- R8: In normal operation, a write to the volume register does not change `vol_o`. `vol_o` changes only on the cycle after a `vol_upd_i` pulse, or on entry to power-down.
- R9: `dac_pd_o` and `flt_rst_o` are driven directly by reference-domain flops and always carry equal values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| mclk_i | input | 1 | Master clock, asynchronous to clk_i |
| wr_en_i | input | 1 | Register write enable |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Register read data |
| vol_upd_i | input | 1 | Volume-update strobe, one cycle |
| dac_pd_o | output | 1 | DAC path power-down |
| flt_rst_o | output | 1 | Digital filter reset |
| vol_o | output | 8 | Applied volume |

## Verification
The assertions assume that the register port and `vol_upd_i` are driven synchronously to `clk_i`, and that `mclk_i` is the only asynchronous input. The bench drives every synchronous input half a cycle away from the active edge and lets only the master-clock generator run freely. The bench also keeps the master-clock period below the loss limit whenever it expects normal operation, so that timer expiry happens only during a deliberate stop.

// File: rtl/mps_pkg.sv
package mps_pkg;
    typedef enum logic {
        PM_RUN  = 1'b0,
        PM_SAVE = 1'b1
    } pmode_e;
endpackage

// File: rtl/mps_clk_sync.sv
module mps_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic edge_o
);
    localparam int DEPTH = STAGES + 1;

    logic [DEPTH-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[DEPTH-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    // a transition seen on the synchronised copy
    assign edge_o = sh_q[DEPTH-1] ^ sh_q[DEPTH-2];
endmodule

// File: rtl/mps_loss_timer.sv
module mps_loss_timer #(
    parameter int LOSS_CYC = 250
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic edge_i,
    output logic timeout_o
);
    localparam int CNT_W = $clog2(LOSS_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(LOSS_CYC - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        if (edge_i)            cnt_d = '0;
        else if (cnt_q == LAST) cnt_d = cnt_q;
        else                   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign timeout_o = !edge_i && (cnt_q == LAST);
endmodule

// File: rtl/mps_regfile.sv
module mps_regfile #(
    parameter int NUM_REGS = 4,
    parameter int DATA_W   = 8,
    parameter int VOL_IDX  = 0
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr_i,
    output logic [DATA_W-1:0]           rd_data_o,
    output logic [DATA_W-1:0]           vol_reg_o
);
    logic [DATA_W-1:0] regs_d [NUM_REGS];
    logic [DATA_W-1:0] regs_q [NUM_REGS];

    always_comb begin
        for (int i = 0; i < NUM_REGS; i++) begin
            regs_d[i] = regs_q[i];
            if (wr_en_i && (int'(wr_addr_i) == i)) regs_d[i] = wr_data_i;
        end
    end

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (!rst_ni) regs_q[g] <= '0;
                else         regs_q[g] <= regs_d[g];
            end
        end
    endgenerate

    assign rd_data_o = regs_q[rd_addr_i];
    assign vol_reg_o = regs_q[VOL_IDX];
endmodule

// File: rtl/mclk_pwrsave.sv
module mclk_pwrsave
    import mps_pkg::*;
#(
    parameter int NUM_REGS    = 4,
    parameter int DATA_W      = 8,
    parameter int VOL_IDX     = 0,
    parameter int LOSS_CYC    = 250,
    parameter int SYNC_STAGES = 2,
    parameter logic [7:0] MUTE_VAL = 8'h00
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic                        mclk_i,
    input  logic                        wr_en_i,
    input  logic [$clog2(NUM_REGS)-1:0] wr_addr_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    input  logic [$clog2(NUM_REGS)-1:0] rd_addr_i,
    output logic [DATA_W-1:0]           rd_data_o,
    input  logic                        vol_upd_i,
    output logic                        dac_pd_o,
    output logic                        flt_rst_o,
    output logic [DATA_W-1:0]           vol_o
);
    localparam logic [DATA_W-1:0] MUTE = DATA_W'(MUTE_VAL);

    typedef struct packed {
        pmode_e            mode;
        logic              pd;
        logic              frst;
        logic [DATA_W-1:0] vol;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic              mclk_edge;
    logic              loss_tmo;
    logic [DATA_W-1:0] vol_reg;

    mps_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (mclk_i),
        .edge_o  (mclk_edge)
    );

    mps_loss_timer #(.LOSS_CYC(LOSS_CYC)) u_timer (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .edge_i    (mclk_edge),
        .timeout_o (loss_tmo)
    );

    mps_regfile #(
        .NUM_REGS (NUM_REGS),
        .DATA_W   (DATA_W),
        .VOL_IDX  (VOL_IDX)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .vol_reg_o (vol_reg)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (mclk_edge)     ctl_d.mode = PM_RUN;
        else if (loss_tmo) ctl_d.mode = PM_SAVE;

        ctl_d.pd   = (ctl_d.mode == PM_SAVE);
        ctl_d.frst = (ctl_d.mode == PM_SAVE);

        if (ctl_d.mode == PM_SAVE)
            ctl_d.vol = MUTE;
        else if (vol_upd_i && ctl_q.mode == PM_RUN)
            ctl_d.vol = vol_reg;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q.mode <= PM_RUN;
            ctl_q.pd   <= 1'b0;
            ctl_q.frst <= 1'b0;
            ctl_q.vol  <= MUTE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign dac_pd_o  = ctl_q.pd;
    assign flt_rst_o = ctl_q.frst;
    assign vol_o     = ctl_q.vol;
endmodule

// File: rtl/mclk_pwrsave_chk.sv
module mclk_pwrsave_chk #(
    parameter int DATA_W = 8,
    parameter logic [7:0] MUTE_VAL = 8'h00
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              dac_pd_o,
    input logic              flt_rst_o,
    input logic [DATA_W-1:0] vol_o,
    input logic              vol_upd_i,
    input logic              mclk_edge,
    input logic              loss_tmo
);
    // R2
    pd_entry_after_timeout_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(dac_pd_o) |-> $past(loss_tmo));

    // R4
    pd_exit_on_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(dac_pd_o) |-> $past(mclk_edge));

    // R5
    muted_in_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_pd_o |-> (vol_o == DATA_W'(MUTE_VAL)));

    // R8
    vol_change_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(vol_o) |-> ($past(vol_upd_i) || dac_pd_o));

    // R9
    pd_frst_equal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dac_pd_o == flt_rst_o);
endmodule

bind mclk_pwrsave mclk_pwrsave_chk #(
    .DATA_W   (DATA_W),
    .MUTE_VAL (MUTE_VAL)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .dac_pd_o  (dac_pd_o),
    .flt_rst_o (flt_rst_o),
    .vol_o     (vol_o),
    .vol_upd_i (vol_upd_i),
    .mclk_edge (mclk_edge),
    .loss_tmo  (loss_tmo)
);

// File: tb/sim_mclk_pwrsave.sv
`timescale 1ns/1ps
module sim_mclk_pwrsave;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mclk = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [1:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       vol_upd = 1'b0;
    logic       dac_pd, flt_rst;
    logic [7:0] vol;

    int  errors = 0;
    int  checks = 0;
    bit  mclk_run = 1'b0;
    real half_ns = 40.7;
    real last_tog = 0.0;

    always #10 clk = ~clk;

    always begin
        if (mclk_run) begin
            #(half_ns);
            if (mclk_run) begin
                mclk = ~mclk;
                last_tog = $realtime;
            end
        end else begin
            #1;
        end
    end

    mclk_pwrsave u0 (
        .clk_i(clk), .rst_ni(rst_n), .mclk_i(mclk),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .rd_addr_i(rd_addr), .rd_data_o(rd_data),
        .vol_upd_i(vol_upd), .dac_pd_o(dac_pd), .flt_rst_o(flt_rst), .vol_o(vol)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); rd_addr = a; #1; d = rd_data;
    endtask

    task automatic strobe();
        @(negedge clk); vol_upd = 1'b1;
        @(negedge clk); vol_upd = 1'b0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        chk(dac_pd == 1'b0, "R1 pd", dac_pd, 0);
        chk(flt_rst == 1'b0, "R1 frst", flt_rst, 0);
        chk(vol == 8'h00, "R1 vol", vol, 0);
        for (int i = 0; i < 4; i++) begin
            rd(2'(i), d);
            chk(d == 8'h00, "R1 reg", d, 0);
        end
    endtask

    task automatic t_running();
        int hi = 0;
        mclk_run = 1'b1;
        repeat (600) begin
            @(negedge clk);
            if (dac_pd) hi++;
        end
        chk(hi == 0, "R3 nominal", hi, 0);
        half_ns = 470.3;
        repeat (1500) begin
            @(negedge clk);
            if (dac_pd) hi++;
        end
        chk(hi == 0, "R3 slow clock", hi, 0);
        half_ns = 40.7;
        repeat (50) @(negedge clk);
    endtask

    task automatic t_normal_write();
        wr(2'd0, 8'h5A);
        repeat (3) @(negedge clk);
        chk(vol == 8'h00, "R8 write no effect", vol, 0);
        strobe();
        chk(vol == 8'h5A, "R8 strobe load", vol, 8'h5A);
        wr(2'd0, 8'h33);
        repeat (2) @(negedge clk);
        chk(vol == 8'h5A, "R8 second write held", vol, 8'h5A);
        wr(2'd2, 8'hC3);
    endtask

    task automatic t_loss();
        real ns;
        int  n = 0;
        mclk_run = 1'b0;
        while (!dac_pd && n < 2000) begin
            @(negedge clk); n++;
        end
        ns = $realtime - last_tog;
        chk(dac_pd == 1'b1, "R2 entered", dac_pd, 1);
        chk(ns >= 2000.0 && ns <= 10000.0, "R2 entry time ns", int'(ns), 5000);
        chk(flt_rst == 1'b1, "R9 frst with pd", flt_rst, 1);
        chk(vol == 8'h00, "R5 muted", vol, 0);
    endtask

    task automatic t_write_ps();
        logic [7:0] d;
        wr(2'd0, 8'h77);
        wr(2'd1, 8'h19);
        strobe();
        repeat (2) @(negedge clk);
        chk(vol == 8'h00, "R5 strobe ignored", vol, 0);
        chk(dac_pd == 1'b1, "R5 still saving", dac_pd, 1);
        rd(2'd0, d); chk(d == 8'h77, "R7 vol reg in save", d, 8'h77);
        rd(2'd1, d); chk(d == 8'h19, "R7 reg1 in save", d, 8'h19);
        rd(2'd2, d); chk(d == 8'hC3, "R7 reg2 kept", d, 8'hC3);
    endtask

    task automatic t_restart();
        real t0, ns;
        int  n = 0;
        logic [7:0] d;
        mclk_run = 1'b1;
        @(posedge mclk or negedge mclk);
        t0 = $realtime;
        while (dac_pd && n < 50) begin
            @(negedge clk); n++;
        end
        ns = $realtime - t0;
        chk(dac_pd == 1'b0, "R4 exited", dac_pd, 0);
        chk(ns <= 80.0, "R4 exit time ns", int'(ns), 80);
        chk(flt_rst == 1'b0, "R9 frst cleared", flt_rst, 0);
        repeat (20) @(negedge clk);
        chk(vol == 8'h00, "R6 muted until strobe", vol, 0);
        strobe();
        chk(vol == 8'h77, "R6 stored volume applied", vol, 8'h77);
        rd(2'd2, d); chk(d == 8'hC3, "R7 reg2 after outage", d, 8'hC3);
    endtask

    initial begin : watchdog
        #3_000_000;
        errors++; checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_running();
        t_normal_write();
        t_loss();
        t_write_ps();
        t_restart();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule